// File: doc/BRIEF.md
# Clock Manager Auto-Relock Controller

This block watches the status outputs of a clock-synthesis unit (a DLL- or PLL-style clock manager) and keeps resetting that unit until it reports a stable lock. It handles a common start-up problem. The input clock may begin outside the unit's supported range and later move to a valid frequency at some unknown moment. A unit that never locked gives no "lost lock" event to react to. This controller therefore retries on its own while the unit is not running, whether or not a lock ever existed.

The controller is clocked by the clock unit's own input clock. It issues single-cycle resets, and after each one it waits a settle interval sized for a 25 MHz input. It then inspects the synchronized status. A healthy unit is left alone and re-inspected after every poll interval. A single down-counter times both intervals. An enable input turns the automatic behaviour on. A sticky flag records that at least one automatic reset has been issued. A user reset request is forwarded to the unit, clears the flag and restarts the settle wait.

Top module: `relock_ctrl`

## Requirements
- R1: While rst_n is low, and afterwards until a reset is requested, unit_rst_o and relock_seen_o are low.
- R2: While en_i is low, no automatic reset is issued, whatever the status inputs show.
- R3: Every automatic reset pulse on unit_rst_o is high for exactly one clock cycle.
- R4: When enabled and the unit is not operating, the first automatic pulse is in the first cycle after reset release, and further pulses follow every SETTLE_CYC+2 cycles.
- R5: The unit counts as not operating when lock_i is low, when clkin_stop_i is high, or (with USE_FX=1) when fx_stop_i is high.
- R6: When the unit is operating, no pulse follows the initial one. The status is re-examined every POLL_CYC+1 cycles, and a loss of health causes a pulse within POLL_CYC+4 cycles.
- R7: relock_seen_o goes high in the same cycle as an automatic pulse and otherwise holds its value.
- R8: A rising edge on user_rst_i yields one unit_rst_o pulse in the next cycle, whatever the value of en_i, and clears relock_seen_o.
- R9: After a user request while enabled, the next automatic pulse can come no sooner than SETTLE_CYC+1 cycles after the forwarded pulse.
- R10: When a user request lands in the cycle an automatic pulse would fire, exactly one one-cycle pulse is produced and relock_seen_o is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, taken from the clock unit's input clock |
| rst_n | input | 1 | Global asynchronous active-low reset |
| en_i | input | 1 | Automatic relock enable |
| user_rst_i | input | 1 | User reset request, acts on its rising edge |
| lock_i | input | 1 | Clock unit lock flag (asynchronous) |
| clkin_stop_i | input | 1 | Input-clock-stopped flag (asynchronous) |
| fx_stop_i | input | 1 | Synthesized-output-stopped flag (asynchronous) |
| unit_rst_o | output | 1 | One-cycle reset pulse to the clock unit |
| relock_seen_o | output | 1 | Sticky flag: an automatic reset has been issued |

## Verification
The user request and the automatic retry can both want the unit reset line in the same cycle. The request also wants the sticky flag cleared in the cycle the retry wants it set. The bench provokes this by holding the unit unhealthy from reset, so that retries fall on a fixed, computable cycle, and by raising the user request so its edge is sampled on exactly that cycle. It judges the outcome by requiring one single-cycle pulse with the flag low afterwards. The next retry must then follow a full settle interval later and set the flag again.

// File: rtl/relock_pkg.sv
package relock_pkg;

  typedef enum logic [2:0] {
    RL_IDLE   = 3'd0,
    RL_PULSE  = 3'd1,
    RL_SETTLE = 3'd2,
    RL_CHECK  = 3'd3,
    RL_POLL   = 3'd4
  } rl_state_t;

  localparam int unsigned STAT_W   = 3;
  localparam int unsigned STAT_LK  = 0;
  localparam int unsigned STAT_IST = 1;
  localparam int unsigned STAT_FST = 2;

endpackage

// File: rtl/rl_sync.sv
module rl_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/rl_wait_timer.sv
module rl_wait_timer #(
  parameter int unsigned SETTLE_CYC = 2500,
  parameter int unsigned POLL_CYC   = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_settle_i,
  input  logic load_poll_i,
  output logic done_o
);

  localparam int unsigned MAX_CYC = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] POLL_LD   = CNT_W'(POLL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done_o = (cnt_q == '0);
  assign cnt_en = load_settle_i | load_poll_i | !done_o;

  always_comb begin
    cnt_d = cnt_q;
    if (load_settle_i) begin
      cnt_d = SETTLE_LD;
    end else if (load_poll_i) begin
      cnt_d = POLL_LD;
    end else if (!done_o) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4: an expired counter stays at zero until it is loaded again
  assert_timer_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_settle_i && !load_poll_i) |=> done_o);

  // R4: a settle load always leaves a non-empty or exact interval
  assert_timer_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_settle_i |=> (cnt_q == SETTLE_LD));

endmodule

// File: rtl/rl_fsm.sv
module rl_fsm
  import relock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic healthy_i,
  input  logic user_req_i,
  input  logic wait_done_i,
  output logic load_settle_o,
  output logic load_poll_o,
  output logic auto_fire_o
);

  rl_state_t state_q;
  rl_state_t state_d;
  logic      auto_q;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = RL_IDLE;
    end else if (user_req_i) begin
      state_d = RL_SETTLE;
    end else begin
      unique case (state_q)
        RL_IDLE:   state_d = RL_PULSE;
        RL_PULSE:  state_d = RL_SETTLE;
        RL_SETTLE: if (wait_done_i) state_d = RL_CHECK;
        RL_CHECK:  state_d = healthy_i ? RL_POLL : RL_PULSE;
        RL_POLL:   if (wait_done_i) state_d = RL_CHECK;
        default:   state_d = RL_IDLE;
      endcase
    end
  end

  assign load_settle_o = (state_d == RL_SETTLE) && ((state_q != RL_SETTLE) || user_req_i);
  assign load_poll_o   = (state_d == RL_POLL) && (state_q != RL_POLL);
  assign auto_fire_o   = (state_d == RL_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RL_IDLE;
      auto_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      auto_q  <= auto_fire_o;
    end
  end

  // R3: automatic pulses never run into a second consecutive cycle
  assert_auto_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q |=> !auto_q);

  // R2: a disabled controller fires nothing in the following cycle
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !auto_q);

  // R4: an expired settle wait always leads to a status check
  assert_settle_to_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RL_SETTLE && wait_done_i && en_i && !user_req_i) |=> (state_q == RL_CHECK));

  // R5: a failed check while enabled retries at once
  assert_check_retry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RL_CHECK && !healthy_i && en_i && !user_req_i) |=> auto_q);

endmodule

// File: rtl/relock_ctrl.sv
module relock_ctrl
  import relock_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 2500,
  parameter int unsigned POLL_CYC   = 25000,
  parameter bit          USE_FX     = 1'b1,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic user_rst_i,
  input  logic lock_i,
  input  logic clkin_stop_i,
  input  logic fx_stop_i,
  output logic unit_rst_o,
  output logic relock_seen_o
);

  logic [STAT_W-1:0] stat_raw;
  logic [STAT_W-1:0] stat_s;
  logic              healthy;
  logic              fx_bad;
  logic              usr_q;
  logic              user_edge;
  logic              load_settle;
  logic              load_poll;
  logic              wait_done;
  logic              auto_fire;
  logic              pulse_q;
  logic              pulse_d;
  logic              seen_q;
  logic              seen_d;
  logic              seen_en;

  assign stat_raw[STAT_LK]  = lock_i;
  assign stat_raw[STAT_IST] = clkin_stop_i;
  assign stat_raw[STAT_FST] = fx_stop_i;

  rl_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (stat_raw),
    .sync_o  (stat_s)
  );

  if (USE_FX) begin : g_fx
    assign fx_bad = stat_s[STAT_FST];
  end else begin : g_nofx
    assign fx_bad = 1'b0;
  end

  assign healthy   = stat_s[STAT_LK] && !stat_s[STAT_IST] && !fx_bad;
  assign user_edge = user_rst_i && !usr_q;

  rl_wait_timer #(.SETTLE_CYC(SETTLE_CYC), .POLL_CYC(POLL_CYC)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_settle_i (load_settle),
    .load_poll_i   (load_poll),
    .done_o        (wait_done)
  );

  rl_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .healthy_i     (healthy),
    .user_req_i    (user_edge),
    .wait_done_i   (wait_done),
    .load_settle_o (load_settle),
    .load_poll_o   (load_poll),
    .auto_fire_o   (auto_fire)
  );

  always_comb begin
    pulse_d = auto_fire | user_edge;
    seen_en = auto_fire | user_edge;
    seen_d  = user_edge ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      usr_q   <= user_rst_i;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (seen_en) begin
      seen_q <= seen_d;
    end
  end

  assign unit_rst_o    = pulse_q;
  assign relock_seen_o = seen_q;

  // R8: a user request edge is forwarded next cycle and clears the flag
  assert_user_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (user_rst_i && !usr_q) |=> (unit_rst_o && !relock_seen_o));

  // R7: the flag only changes on an automatic pulse or a user request
  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_fire && !user_edge) |=> $stable(relock_seen_o));

  // R7: an automatic pulse without a user request raises the flag with it
  assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_fire && !user_edge) |=> (unit_rst_o && relock_seen_o));

  // R1: nothing is driven toward the unit while disabled and not requested
  assert_quiet_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !user_edge) |=> !unit_rst_o);

endmodule

// File: tb/relock_ctrl_test.sv
module relock_ctrl_test;

  localparam int unsigned S = 6;
  localparam int unsigned P = 10;
  localparam int WIN = 64;

  // fields: [8] en, [7] lock, [6] clkin stopped, [5] fx stopped,
  //         [4:1] expected pulses in WIN cycles, [0] expected sticky flag
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b0, 4'd8, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b1, 4'd8, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b1, 4'd8, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0;
  logic user_rst_i = 1'b0;
  logic lock_i = 1'b0;
  logic clkin_stop_i = 1'b0;
  logic fx_stop_i = 1'b0;
  logic unit_rst_o;
  logic relock_seen_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  relock_ctrl #(.SETTLE_CYC(S), .POLL_CYC(P), .USE_FX(1'b1)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .user_rst_i    (user_rst_i),
    .lock_i        (lock_i),
    .clkin_stop_i  (clkin_stop_i),
    .fx_stop_i     (fx_stop_i),
    .unit_rst_o    (unit_rst_o),
    .relock_seen_o (relock_seen_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_window(input int n, output int pulses, output int maxrun);
    int run;
    bit prev;
    pulses = 0; maxrun = 0; run = 0; prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (unit_rst_o && !prev) pulses++;
      run = unit_rst_o ? run + 1 : 0;
      if (run > maxrun) maxrun = run;
      prev = unit_rst_o;
    end
  endtask

  task automatic wait_pulse(input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (unit_rst_o && k < 0) k = i;
    end
  endtask

  initial begin
    int np, mr, worst, k;
    worst = 0;

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(unit_rst_o == 1'b0, "R1 rst pulse", unit_rst_o, 0);
    check(relock_seen_o == 1'b0, "R1 rst sticky", relock_seen_o, 0);

    // table walk: R2, R4, R5, R6, R7
    for (int v = 0; v < 8; v++) begin
      en_i = VEC[v][8]; lock_i = VEC[v][7];
      clkin_stop_i = VEC[v][6]; fx_stop_i = VEC[v][5];
      do_reset();
      run_window(WIN, np, mr);
      if (mr > worst) worst = mr;
      check(np == int'(VEC[v][4:1]), "R2/R4/R5/R6 pulse count", np, int'(VEC[v][4:1]));
      check(relock_seen_o == VEC[v][0], "R7 sticky after window", relock_seen_o, VEC[v][0]);
    end
    check(worst <= 1, "R3 pulse width", worst, 1);

    // R4: retry spacing SETTLE+2
    en_i = 1'b1; lock_i = 1'b0; clkin_stop_i = 1'b0; fx_stop_i = 1'b0;
    do_reset();
    @(negedge clk);
    check(unit_rst_o == 1'b1, "R4 first pulse", unit_rst_o, 1);
    check(relock_seen_o == 1'b1, "R7 sticky with pulse", relock_seen_o, 1);
    wait_pulse(S + 2, k);
    check(k == S + 2, "R4 retry spacing", k, S + 2);

    // R6: healthy unit losing lock during polling
    lock_i = 1'b1;
    do_reset();
    run_window(30, np, mr);
    check(np == 1, "R6 healthy quiet", np, 1);
    lock_i = 1'b0;
    wait_pulse(P + 4, k);
    check(k >= 2 && k <= P + 4, "R6 loss detected", k, P + 4);

    // R8, R9: user request restarts settle
    lock_i = 1'b1;
    do_reset();
    run_window(30, np, mr);
    user_rst_i = 1'b1; lock_i = 1'b0;
    @(negedge clk);
    check(unit_rst_o == 1'b1, "R8 forwarded pulse", unit_rst_o, 1);
    check(relock_seen_o == 1'b0, "R8 sticky cleared", relock_seen_o, 1'b0);
    user_rst_i = 1'b0;
    wait_pulse(S + 1, k);
    check(k == S + 1, "R9 next retry after user", k, S + 1);

    // R8, R2: user request while disabled
    en_i = 1'b0;
    repeat (4) @(negedge clk);
    check(relock_seen_o == 1'b1, "R2 sticky held while disabled", relock_seen_o, 1);
    user_rst_i = 1'b1;
    @(negedge clk);
    check(unit_rst_o == 1'b1, "R8 pulse when disabled", unit_rst_o, 1);
    check(relock_seen_o == 1'b0, "R8 clear when disabled", relock_seen_o, 0);
    @(negedge clk);
    check(unit_rst_o == 1'b0, "R3 user pulse width", unit_rst_o, 0);
    run_window(30, np, mr);
    check(np == 0, "R2 no pulses while disabled", np, 0);
    check(relock_seen_o == 1'b0, "R8 flag stays clear", relock_seen_o, 0);
    user_rst_i = 1'b0;

    // R10: user request on the cycle of an automatic retry
    en_i = 1'b1; lock_i = 1'b0;
    do_reset();
    repeat (16) @(negedge clk);
    user_rst_i = 1'b1;
    @(negedge clk);
    check(unit_rst_o == 1'b1, "R10 single pulse high", unit_rst_o, 1);
    check(relock_seen_o == 1'b0, "R10 clear wins", relock_seen_o, 0);
    @(negedge clk);
    check(unit_rst_o == 1'b0, "R10 pulse one cycle", unit_rst_o, 0);
    user_rst_i = 1'b0;
    wait_pulse(S, k);
    check(k == S, "R10 retry after restart", k, S);
    check(relock_seen_o == 1'b1, "R7 flag set again", relock_seen_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule